// File: doc/BRIEF.md
# Two-Wire Bus Condition Monitor

This block listens to the clock and data lines of a two-wire open-drain serial bus and turns what it sees into protocol events. It never drives either line. It has no notion of addresses or data bytes. Both lines pass through a two-flop synchronizer and then a short glitch filter. After that, the block compares each filtered level with its value one cycle earlier. From these edges it raises one-cycle pulses for a start, a repeated start, a stop and an aborted transfer.

The block keeps a count of clock rising edges since the last start, from 1 to 9. This count marks where the bus is within a byte. A data-line change while the clock is high is treated as follows:

- At a byte boundary, it is read as a start or a stop.
- Inside a byte, it aborts the transaction.

A busy flag rises at a start. It stays up for a parameterized number of system clocks after the transaction ends, whether the end was a stop or an abort. While the power-down input is high, any start also produces a wake-up pulse. A power manager can use that pulse to bring the rest of the chip back up.

Top module: `bus_cond_monitor`

## Requirements
- R1: With no transaction open, a falling data line while the filtered clock line is high produces exactly one `start_pulse`, and `busy` is high on the following cycle.
- R2: A falling data line while the clock is high and a transaction is open produces `rstart_pulse` and no `start_pulse`.
- R3: A rising data line while the clock is high produces exactly one `stop_pulse` (unless R5 applies), and the transaction closes.
- R4: After the cycle in which `stop_pulse` or `abort_pulse` is high, `busy` stays high for exactly FREE_CLKS further cycles (default 16) before falling, provided no new start occurs.
- R5: In an open transaction, when 2 to 8 clock rising edges have been seen since the last start or repeated start, any data-line change while the clock is high produces `abort_pulse` only, and the transaction closes.
- R6: When the count of clock rising edges since the last start is 0, 1 or 9, a data-line change while the clock is high is a start/repeated start or a stop, never an abort. The count wraps from 9 back to 1.
- R7: `wake_pulse` coincides with every `start_pulse` or `rstart_pulse` while `pwr_down` is 1, and never fires while `pwr_down` is 0.
- R8: Data-line changes while the clock line is low produce no event pulse.
- R9: A level on either line that lasts fewer than FILT_LEN synchronized samples (default 3) is ignored and produces no event.
- R10: During and right after reset, all pulse outputs and `busy` are 0, and both lines are taken as idle high.
- R11: At most one of `start_pulse`, `rstart_pulse`, `stop_pulse` and `abort_pulse` is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_line | input | 1 | Serial clock line level as seen on the pin |
| sda_line | input | 1 | Serial data line level as seen on the pin |
| pwr_down | input | 1 | High while the chip is in power-down |
| start_pulse | output | 1 | One-cycle pulse on a start from idle |
| rstart_pulse | output | 1 | One-cycle pulse on a repeated start |
| stop_pulse | output | 1 | One-cycle pulse on a stop |
| abort_pulse | output | 1 | One-cycle pulse on a mid-byte data change while the clock is high |
| busy | output | 1 | Bus occupied: transaction open or bus-free delay running |
| wake_pulse | output | 1 | One-cycle pulse on any start while powered down |

## Verification
Random transactions are generated with 1 to 3 bytes each, random data and acknowledge bits, optional repeated starts, optional injected mid-byte aborts, and a random power-down level. A bench model predicts the one expected event for every line change. These runs separate three cases: data moving under a low clock, start or stop at a byte boundary, and an illegal change inside a byte. Directed cases cover the rest:

- an edge placed at bit count 1 against one at count 2, which pins down the abort boundary;
- a sub-filter-length glitch on an idle bus;
- a start with power-down low;
- a cycle-exact measurement of how long `busy` lingers after a stop.

// File: rtl/bus_cond_pkg.sv
// Shared definitions for the two-wire bus condition monitor.
// Assumes a byte of eight data bits followed by one acknowledge bit.
package bus_cond_pkg;
    localparam int BITS_PER_BYTE = 8;
    localparam int ACK_SLOT      = BITS_PER_BYTE + 1;

    typedef enum logic [2:0] {
        EV_NONE,
        EV_START,
        EV_RSTART,
        EV_STOP,
        EV_ABORT
    } bus_ev_e;
endpackage

// File: rtl/bcm_line_filter.sv
// Synchronizes one bus line into the clock domain and removes glitches.
// The output follows the input only after FILT_LEN consecutive equal
// synchronized samples; otherwise it holds. Resets to the idle-high level.
module bcm_line_filter #(
    parameter int FILT_LEN = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic raw,
    output logic clean
);
    logic              sync_a;
    logic              sync_b;
    logic [FILT_LEN-1:0] hist;

    // two-flop synchronizer, idle level is high
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_a <= 1'b1;
            sync_b <= 1'b1;
        end else begin
            sync_a <= raw;
            sync_b <= sync_a;
        end
    end

    // sample history used by the agreement test
    always_ff @(posedge clk) begin
        if (!rst_n) hist <= '1;
        else        hist <= {hist[FILT_LEN-2:0], sync_b};
    end

    // move the clean level only on full agreement
    always_ff @(posedge clk) begin
        if (!rst_n)             clean <= 1'b1;
        else if (&hist)         clean <= 1'b1;
        else if (hist == '0)    clean <= 1'b0;
    end
endmodule

// File: rtl/bcm_event_decode.sv
// Classifies filtered line edges into bus events. Tracks whether a
// transaction is open and how many clock rising edges followed the last
// start (0..9, wrapping 9 -> 1). Assumes both inputs are glitch-free.
module bcm_event_decode
    import bus_cond_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    scl,
    input  logic    sda,
    output bus_ev_e ev,
    output logic    in_xfer
);
    localparam int CNT_W = $clog2(ACK_SLOT + 1);

    logic             scl_q;
    logic             sda_q;
    logic [CNT_W-1:0] edge_cnt;
    logic             clk_high;
    logic             sda_fell;
    logic             sda_rose;
    logic             inside_byte;

    assign clk_high    = scl && scl_q;
    assign sda_fell    = clk_high && sda_q && !sda;
    assign sda_rose    = clk_high && !sda_q && sda;
    assign inside_byte = in_xfer && (edge_cnt >= CNT_W'(2)) &&
                         (edge_cnt <= CNT_W'(BITS_PER_BYTE));

    // pick the single event for this cycle
    always_comb begin
        ev = EV_NONE;
        if ((sda_fell || sda_rose) && inside_byte) ev = EV_ABORT;
        else if (sda_fell)                         ev = in_xfer ? EV_RSTART : EV_START;
        else if (sda_rose)                         ev = EV_STOP;
    end

    // previous filtered levels for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl;
            sda_q <= sda;
        end
    end

    // transaction state and bit position
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            in_xfer  <= 1'b0;
            edge_cnt <= '0;
        end else begin
            case (ev)
                EV_START, EV_RSTART: begin
                    in_xfer  <= 1'b1;
                    edge_cnt <= '0;
                end
                EV_STOP, EV_ABORT: in_xfer <= 1'b0;
                default: begin
                    if (scl && !scl_q)
                        edge_cnt <= (edge_cnt == CNT_W'(ACK_SLOT)) ? CNT_W'(1)
                                                                   : edge_cnt + CNT_W'(1);
                end
            endcase
        end
    end
endmodule

// File: rtl/bcm_free_timer.sv
// Bus-free delay: loads FREE_CLKS when a transaction ends and counts down
// to zero; running is high while the count is non-zero.
module bcm_free_timer #(
    parameter int FREE_CLKS = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    output logic running
);
    localparam int TMR_W = $clog2(FREE_CLKS + 1);

    logic [TMR_W-1:0] remain;

    // reload on end of transaction, else count down
    always_ff @(posedge clk) begin
        if (!rst_n)              remain <= '0;
        else if (load)           remain <= TMR_W'(FREE_CLKS);
        else if (remain != '0)   remain <= remain - TMR_W'(1);
    end

    assign running = (remain != '0);
endmodule

// File: rtl/bus_cond_monitor.sv
// Top of the two-wire bus condition monitor. Filters both lines, decodes
// start / repeated start / stop / abort, holds busy through a bus-free
// delay and raises a wake-up pulse on any start during power-down.
// Assumes line inputs are asynchronous to clk; never drives the bus.
module bus_cond_monitor
    import bus_cond_pkg::*;
#(
    parameter int FILT_LEN  = 3,
    parameter int FREE_CLKS = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_line,
    input  logic sda_line,
    input  logic pwr_down,
    output logic start_pulse,
    output logic rstart_pulse,
    output logic stop_pulse,
    output logic abort_pulse,
    output logic busy,
    output logic wake_pulse
);
    localparam int N_LINES = 2;

    logic [N_LINES-1:0] raw_lines;
    logic [N_LINES-1:0] clean_lines;
    bus_ev_e            ev;
    logic               in_xfer;
    logic               delay_on;

    assign raw_lines = {sda_line, scl_line};

    // one synchronizer and filter per bus line
    for (genvar i = 0; i < N_LINES; i++) begin : g_line
        bcm_line_filter #(.FILT_LEN(FILT_LEN)) u_filt (
            .clk   (clk),
            .rst_n (rst_n),
            .raw   (raw_lines[i]),
            .clean (clean_lines[i])
        );
    end

    bcm_event_decode u_dec (
        .clk     (clk),
        .rst_n   (rst_n),
        .scl     (clean_lines[0]),
        .sda     (clean_lines[1]),
        .ev      (ev),
        .in_xfer (in_xfer)
    );

    bcm_free_timer #(.FREE_CLKS(FREE_CLKS)) u_tmr (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (stop_pulse || abort_pulse),
        .running (delay_on)
    );

    // event pulses and status outputs
    always_comb begin
        start_pulse  = (ev == EV_START);
        rstart_pulse = (ev == EV_RSTART);
        stop_pulse   = (ev == EV_STOP);
        abort_pulse  = (ev == EV_ABORT);
        wake_pulse   = pwr_down && (start_pulse || rstart_pulse);
        busy         = in_xfer || delay_on;
    end
endmodule

// File: rtl/bus_cond_monitor_chk.sv
// Temporal checks on the monitor outputs, bound into every instance.
module bus_cond_monitor_chk (
    input logic clk,
    input logic rst_n,
    input logic pwr_down,
    input logic start_pulse,
    input logic rstart_pulse,
    input logic stop_pulse,
    input logic abort_pulse,
    input logic busy,
    input logic wake_pulse
);
    p_start_busy_r1: assert property (@(posedge clk) disable iff (!rst_n)
        start_pulse |=> busy);
    p_rstart_in_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
        rstart_pulse |-> busy);
    p_stop_holds_busy_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_pulse || abort_pulse) |=> busy);
    p_busy_fall_late_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> !$past(stop_pulse) && !$past(abort_pulse));
    p_abort_in_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
        abort_pulse |-> busy);
    p_wake_pd_only_r7: assert property (@(posedge clk) disable iff (!rst_n)
        wake_pulse |-> pwr_down && (start_pulse || rstart_pulse));
    p_one_event_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({start_pulse, rstart_pulse, stop_pulse, abort_pulse}));
    p_wake_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
        wake_pulse |=> !wake_pulse);
endmodule

bind bus_cond_monitor bus_cond_monitor_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .pwr_down     (pwr_down),
    .start_pulse  (start_pulse),
    .rstart_pulse (rstart_pulse),
    .stop_pulse   (stop_pulse),
    .abort_pulse  (abort_pulse),
    .busy         (busy),
    .wake_pulse   (wake_pulse)
);

// File: tb/tb_bus_cond_monitor.sv
module tb_bus_cond_monitor;
    localparam int FREE_CLKS = 16;
    localparam int HOLD      = 12;
    localparam int EV_N = 0, EV_S = 1, EV_RS = 2, EV_P = 3, EV_A = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl_line = 1'b1;
    logic sda_line = 1'b1;
    logic pwr_down = 1'b0;
    logic start_pulse, rstart_pulse, stop_pulse, abort_pulse, busy, wake_pulse;

    int total = 0;
    int bad = 0;

    // bench model of the bus
    logic m_scl = 1'b1;
    logic m_sda = 1'b1;
    logic m_act = 1'b0;
    int   m_cnt = 0;

    always #10 clk = ~clk;

    bus_cond_monitor #(.FILT_LEN(3), .FREE_CLKS(FREE_CLKS)) dut (
        .clk(clk), .rst_n(rst_n), .scl_line(scl_line), .sda_line(sda_line),
        .pwr_down(pwr_down), .start_pulse(start_pulse), .rstart_pulse(rstart_pulse),
        .stop_pulse(stop_pulse), .abort_pulse(abort_pulse), .busy(busy),
        .wake_pulse(wake_pulse)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // expected event for one line change, from the requirements
    function automatic int predict(input logic ns, input logic nd);
        int code = EV_N;
        if (ns && !m_scl) begin
            m_cnt = (m_cnt == 9) ? 1 : m_cnt + 1;
        end else if (ns && m_scl && nd != m_sda) begin
            if (m_act && m_cnt >= 2 && m_cnt <= 8) code = EV_A;       // R5
            else if (!nd) code = m_act ? EV_RS : EV_S;               // R1 R2 R6
            else code = EV_P;                                        // R3
            if (code == EV_S || code == EV_RS) begin
                m_act = 1'b1;
                m_cnt = 0;
            end else m_act = 1'b0;
        end
        m_scl = ns;
        m_sda = nd;
        return code;
    endfunction

    // drive one line change, observe a window, compare event counts
    task automatic step(input logic ns, input logic nd);
        int code, ns_c, nrs_c, np_c, na_c, nw_c;
        bit multi;
        string tag;
        if (ns == m_scl && nd == m_sda) return;
        code = predict(ns, nd);
        scl_line = ns;
        sda_line = nd;
        ns_c = 0; nrs_c = 0; np_c = 0; na_c = 0; nw_c = 0; multi = 0;
        repeat (HOLD) begin
            @(negedge clk);
            ns_c += int'(start_pulse);
            nrs_c += int'(rstart_pulse);
            np_c += int'(stop_pulse);
            na_c += int'(abort_pulse);
            nw_c += int'(wake_pulse);
            if (int'(start_pulse) + int'(rstart_pulse) + int'(stop_pulse)
                + int'(abort_pulse) > 1) multi = 1;
        end
        case (code)
            EV_S: tag = "R1 start"; EV_RS: tag = "R2/R6 rstart";
            EV_P: tag = "R3 stop";  EV_A:  tag = "R5 abort";
            default: tag = "R8 no event";
        endcase
        chk(ns_c == int'(code == EV_S), {tag, " start count"}, ns_c, int'(code == EV_S));
        chk(nrs_c == int'(code == EV_RS), {tag, " rstart count"}, nrs_c, int'(code == EV_RS));
        chk(np_c == int'(code == EV_P), {tag, " stop count"}, np_c, int'(code == EV_P));
        chk(na_c == int'(code == EV_A), {tag, " abort count"}, na_c, int'(code == EV_A));
        chk(nw_c == int'(pwr_down && (code == EV_S || code == EV_RS)),
            "R7 wake count", nw_c, int'(pwr_down && (code == EV_S || code == EV_RS)));
        chk(!multi, "R11 one event per cycle", int'(multi), 0);
        if (code == EV_S || code == EV_RS) chk(busy, "R1 busy after start", busy, 1);
    endtask

    task automatic idle_check();
        repeat (FREE_CLKS + 10) @(negedge clk);
        chk(!busy, "R4 busy low after free delay", busy, 0);
    endtask

    task automatic send_bits(input int n, input int abort_at);
        for (int b = 1; b <= n; b++) begin
            logic v;
            v = 1'($urandom_range(0, 1));
            step(1'b0, m_sda);
            step(1'b0, v);
            step(1'b1, v);
            if (b == abort_at) begin
                step(1'b1, !v);
                return;
            end
        end
    endtask

    task automatic end_with_stop();
        step(1'b0, m_sda);
        step(1'b0, 1'b0);
        step(1'b1, 1'b0);
        step(1'b1, 1'b1);
    endtask

    task automatic rand_xfer();
        int nseg, nbytes, abort_at;
        pwr_down = 1'($urandom_range(0, 1));
        step(1'b1, 1'b0);
        nseg = $urandom_range(1, 2);
        for (int s = 0; s < nseg; s++) begin
            nbytes = $urandom_range(1, 3);
            abort_at = ($urandom_range(0, 3) == 0) ? $urandom_range(2, 8) : 0;
            send_bits(9 * (nbytes - 1), 0);
            send_bits(9, abort_at);
            if (abort_at != 0) break;
            if (s + 1 < nseg) begin
                step(1'b0, m_sda);
                step(1'b0, 1'b1);
                step(1'b1, 1'b1);
                step(1'b1, 1'b0);
            end
        end
        end_with_stop();
        idle_check();
    endtask

    // watchdog
    initial begin
        #(20 * 190000);
        total++;
        bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int len;
        void'($urandom(32'h0B5C_11E5));
        repeat (4) @(negedge clk);
        chk(!start_pulse && !rstart_pulse && !stop_pulse && !abort_pulse && !wake_pulse,
            "R10 pulses low in reset", 0, 0);
        chk(!busy, "R10 busy low in reset", busy, 0);
        rst_n = 1'b1;
        repeat (8) @(negedge clk);
        chk(!busy && !start_pulse && !stop_pulse, "R10 idle after reset", busy, 0);

        // R9: short data glitch on idle bus
        sda_line = 1'b0;
        @(negedge clk); @(negedge clk);
        sda_line = 1'b1;
        len = 0;
        repeat (HOLD) begin
            @(negedge clk);
            len += int'(start_pulse) + int'(stop_pulse) + int'(busy);
        end
        chk(len == 0, "R9 glitch ignored", len, 0);

        // R7: start with power-down low, then R6/R5 boundary, R4 timing
        pwr_down = 1'b0;
        step(1'b1, 1'b0);
        step(1'b0, 1'b0); step(1'b0, 1'b1); step(1'b1, 1'b1);   // count 1
        step(1'b1, 1'b0);                                        // R6 rstart
        step(1'b0, 1'b0); step(1'b1, 1'b0);                      // count 1
        step(1'b0, 1'b0); step(1'b1, 1'b0);                      // count 2
        step(1'b1, 1'b1);                                        // R5 abort
        idle_check();

        // R4: exact busy hold after stop
        pwr_down = 1'b1;
        step(1'b1, 1'b0);
        step(1'b0, 1'b0); step(1'b1, 1'b0);
        m_sda = 1'b1; m_act = 1'b0;
        sda_line = 1'b1;
        len = -1;
        for (int k = 0; k < 40; k++) begin
            @(negedge clk);
            if (len >= 0 && busy) len++;
            if (stop_pulse) len = 0;
        end
        chk(len == FREE_CLKS, "R4 busy hold length", len, FREE_CLKS);

        for (int t = 0; t < 60; t++) rand_xfer();

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule